// File: doc/BRIEF.md
# Synchronous Flow-Through Burst Static RAM

This block is a synthesizable model of a synchronous static RAM meant to serve as the data store of a cache. The word count is a parameter, and each word is a set of 9-bit byte lanes. On every rising clock edge the block samples the address, the write data and its control inputs. One of two start strobes then begins a burst. The first strobe comes from the processor side and the second from the cache controller side. The start address is loaded on that edge. Later beats of the same burst take their two low address bits from an internal 2-bit counter, which steps only while the advance input is high.

The order of the counter is set by a static select input. In linear order the low bits count up modulo 4. In interleaved order the low bits are the start bits XORed with the beat count. A write may target single byte lanes or the whole word, and it is performed on the clock edge with no external pulse.

Read data is not registered at the output. It flows straight from the array at the registered address, so it is valid in the cycle just after the edge that loaded the address. The output drive flag is combinational in output enable and sleep. The flag is meant to control a tristate pad driver. While the flag is low, the data output reads zero, which stands for high impedance.

Top module: `fthru_burst_sram`

## Requirements
- R1: An edge with `ce` high and `ps_start` or `cs_start` high loads `addr`. In the cycle after that edge, a read shows `mem[addr]` on `dout`.
- R2: On an edge during an active burst with no strobe high, `adv` high moves to the next beat. With `adv` low the current address is held, and so are the data it shows.
- R3: With `order_ilv` = 0, beat k (k = 0, 1, 2, ...) of a burst started at address s reads address {s[AW-1:2], (s[1:0]+k) mod 4}. The upper bits never change, and after four beats the sequence wraps back to s.
- R4: With `order_ilv` = 1, beat k reads {s[AW-1:2], s[1:0] XOR (k mod 4)}.
- R5: In a controller-started or continuing cycle with `we` = 1 and `gw` = 0, byte lane i (bits 9i+8 down to 9i) is written from `din` only when `bw[i]` = 1. All other lanes keep their contents.
- R6: When `gw` = 1, or when `we` = 1 with every `bw` bit high, all lanes are written. When `we` = 0 and `gw` = 0, nothing is written whatever `bw` holds, and the cycle is a read.
- R7: A burst started by `ps_start` is a read in its first cycle and ignores `we`, `gw` and `bw`. If both strobes are high, `ps_start` wins.
- R8: `dout_drv` is high only when the current cycle is a read, `oe` = 1 and `sleep` = 0. `oe` acts without a clock edge. A write cycle never drives, and `dout` is 0 whenever `dout_drv` is low.
- R9: An edge with `ce` low and either strobe high deselects the block. `dout_drv` is low in the very next cycle, and later cycles without a strobe stay idle.
- R10: While `sleep` = 1, no write takes place, the burst address and counter are held, and `dout_drv` is low. Once `sleep` returns to 0, the held read reappears.
- R11: A synchronous reset (`rst` high on an edge) leaves the block idle with `dout_drv` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Burst start address |
| ps_start | input | 1 | Processor-side burst start strobe (read start, has priority) |
| cs_start | input | 1 | Controller-side burst start strobe |
| ce | input | 1 | Chip enable; low with a strobe deselects |
| adv | input | 1 | Advance the burst counter |
| we | input | 1 | Write enable qualifying the byte selects |
| gw | input | 1 | Global write of all lanes |
| bw | input | LANES | Per-lane byte write selects |
| din | input | 9*LANES | Write data |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep: blocks all accesses |
| dout | output | 9*LANES | Flow-through read data (0 when not driven) |
| dout_drv | output | 1 | Pad drive enable for dout |

## Verification
The bench fills the array with linear write bursts. It then reads every start address in both orders through five beats. A wrong order function, or a counter that carries into the upper bits, returns the wrong word on some beat. A counter that fails to wrap shows up on the fifth beat.

Further tests cover the write controls:
- Single-lane writes at the start beat and on a continuing beat. A design that writes the whole word changes the lane that should have been kept.
- Byte selects issued with `we` low. A design that skips the `we` qualification corrupts memory.
- Write controls presented on a processor start, and on a start with both strobes high. A design that wrongly honours them shows the new data, or drops the output drive.

Finally, deselect, sleep during a write burst, and asynchronous `oe` toggling are checked. Any cycle of extra output drive is detected, and so is a write or counter step that slipped through while sleep was high.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [2:0] {
    CK_HOLD,
    CK_DESEL,
    CK_START_P,
    CK_START_C,
    CK_CONT
  } cyc_e;

  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/fbs_cycle_decode.sv
module fbs_cycle_decode
  import fbs_pkg::*;
(
  input  logic ps_start,
  input  logic cs_start,
  input  logic ce,
  input  logic sleep,
  input  logic active,
  output cyc_e kind
);
  always_comb begin
    if (sleep)                     kind = CK_HOLD;
    else if (ps_start || cs_start) begin
      if (!ce)                     kind = CK_DESEL;
      else if (ps_start)           kind = CK_START_P;
      else                         kind = CK_START_C;
    end
    else if (active)               kind = CK_CONT;
    else                           kind = CK_HOLD;
  end
endmodule

// File: rtl/fbs_write_qual.sv
module fbs_write_qual
  import fbs_pkg::*;
#(
  parameter int LANES = 2
) (
  input  cyc_e             kind,
  input  logic             we,
  input  logic             gw,
  input  logic [LANES-1:0] bw,
  output logic [LANES-1:0] wr_mask
);
  logic may_write;

  assign may_write = (kind == CK_START_C) || (kind == CK_CONT);

  always_comb begin
    wr_mask = '0;
    if (may_write) begin
      if (gw)      wr_mask = '1;
      else if (we) wr_mask = bw;
    end
  end
endmodule

// File: rtl/fbs_burst_addr.sv
module fbs_burst_addr
  import fbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          kind,
  input  logic [AW-1:0] addr_in,
  input  logic          adv,
  input  logic          ilv,
  input  logic          wr_any,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] cur_addr,
  output logic          active,
  output logic          rd_valid
);
  logic [1:0] base_lo;
  logic [1:0] beat;
  logic [1:0] beat_nxt;

  always_comb begin
    eff_addr = cur_addr;
    beat_nxt = beat;
    case (kind)
      CK_START_P, CK_START_C: begin
        eff_addr = addr_in;
        beat_nxt = 2'd0;
      end
      CK_CONT: begin
        if (adv) begin
          beat_nxt = beat + 2'd1;
          eff_addr = {cur_addr[AW-1:2], burst_low(base_lo, beat + 2'd1, ilv)};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      base_lo  <= 2'd0;
      beat     <= 2'd0;
      active   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      case (kind)
        CK_START_P, CK_START_C: begin
          cur_addr <= eff_addr;
          base_lo  <= addr_in[1:0];
          beat     <= beat_nxt;
          active   <= 1'b1;
          rd_valid <= !wr_any;
        end
        CK_CONT: begin
          cur_addr <= eff_addr;
          beat     <= beat_nxt;
          rd_valid <= !wr_any;
        end
        CK_DESEL: begin
          active   <= 1'b0;
          rd_valid <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fbs_array.sv
module fbs_array
  import fbs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int W  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] wr_mask,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/fthru_burst_sram.sv
module fthru_burst_sram
  import fbs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int W  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             ps_start,
  input  logic             cs_start,
  input  logic             ce,
  input  logic             adv,
  input  logic             we,
  input  logic             gw,
  input  logic [LANES-1:0] bw,
  input  logic [W-1:0]     din,
  input  logic             order_ilv,
  input  logic             oe,
  input  logic             sleep,
  output logic [W-1:0]     dout,
  output logic             dout_drv
);
  cyc_e             kind;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    cur_addr;
  logic             active;
  logic             rd_valid;
  logic [W-1:0]     rdata;

  fbs_cycle_decode u_dec (
    .ps_start (ps_start),
    .cs_start (cs_start),
    .ce       (ce),
    .sleep    (sleep),
    .active   (active),
    .kind     (kind)
  );

  fbs_write_qual #(.LANES(LANES)) u_wq (
    .kind    (kind),
    .we      (we),
    .gw      (gw),
    .bw      (bw),
    .wr_mask (wr_mask)
  );

  fbs_burst_addr #(.AW(AW)) u_ag (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .addr_in  (addr),
    .adv      (adv),
    .ilv      (order_ilv),
    .wr_any   (|wr_mask),
    .eff_addr (eff_addr),
    .cur_addr (cur_addr),
    .active   (active),
    .rd_valid (rd_valid)
  );

  fbs_array #(.DEPTH(DEPTH), .LANES(LANES)) u_mem (
    .clk     (clk),
    .wr_mask (wr_mask),
    .waddr   (eff_addr),
    .wdata   (din),
    .raddr   (cur_addr),
    .rdata   (rdata)
  );

  assign dout_drv = rd_valid && oe && !sleep;
  assign dout     = dout_drv ? rdata : '0;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int DEPTH = 64,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             ps_start,
  input logic             cs_start,
  input logic             ce,
  input logic             adv,
  input logic             sleep,
  input logic             dout_drv,
  input logic             rd_valid,
  input logic [AW-1:0]    cur_addr,
  input logic [LANES-1:0] wr_mask
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ps_start && !cs_start && !adv) |=> $stable(cur_addr));

  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (!ps_start && !cs_start) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  p_ps_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (ps_start && ce) |-> (wr_mask == '0));

  p_ps_reads_r7: assert property (@(posedge clk) disable iff (rst)
    (ps_start && ce && !sleep) |=> rd_valid);

  p_write_no_read_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_mask != '0) |=> !rd_valid);

  p_deselect_r9: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !ce && (ps_start || cs_start)) |=> !rd_valid);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!dout_drv && wr_mask == '0));

  p_sleep_hold_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(cur_addr));
endmodule

bind fthru_burst_sram fbs_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ps_start (ps_start),
  .cs_start (cs_start),
  .ce       (ce),
  .adv      (adv),
  .sleep    (sleep),
  .dout_drv (dout_drv),
  .rd_valid (rd_valid),
  .cur_addr (cur_addr),
  .wr_mask  (wr_mask)
);

// File: tb/fthru_burst_sram_tb_top.sv
module fthru_burst_sram_tb_top;
  localparam int DEPTH = 16;
  localparam int LANES = 2;
  localparam int AW = 4;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ps_start = 0, cs_start = 0, ce = 1, adv = 0, we = 0, gw = 0;
  logic [LANES-1:0] bw = '0;
  logic [W-1:0] din = '0;
  logic order_ilv = 0, oe = 1, sleep = 0;
  logic [W-1:0] dout;
  logic dout_drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] ref_mem [0:DEPTH-1];

  always #5 clk = ~clk;

  fthru_burst_sram #(.DEPTH(DEPTH), .LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .ps_start(ps_start), .cs_start(cs_start),
    .ce(ce), .adv(adv), .we(we), .gw(gw), .bw(bw), .din(din),
    .order_ilv(order_ilv), .oe(oe), .sleep(sleep), .dout(dout), .dout_drv(dout_drv)
  );

  function automatic logic [W-1:0] pat(input int a, input int salt);
    return W'((a * 613 + salt * 97 + 11) ^ (a << 9));
  endfunction

  function automatic int beat_addr(input int s, input int k, input bit ilv);
    int lo;
    lo = ilv ? ((s & 3) ^ (k & 3)) : (((s & 3) + k) & 3);
    return (s & ~3) | lo;
  endfunction

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_read(input string req, input int a);
    chk(dout_drv === 1'b1, req, W'(dout_drv), W'(1));
    chk(dout === ref_mem[a], req, dout, ref_mem[a]);
  endtask

  task automatic idle_ctl;
    ps_start = 0; cs_start = 0; ce = 1; adv = 0; we = 0; gw = 0; bw = '0;
  endtask

  task automatic ps_read(input int a);
    idle_ctl(); ps_start = 1; addr = AW'(a);
    tick();
    ps_start = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    chk(dout_drv === 1'b0, "R11 idle after reset", W'(dout_drv), W'(0));

    // Fill with linear write bursts, global write; writes must not drive (R8)
    for (int b = 0; b < DEPTH / 4; b++) begin
      idle_ctl(); cs_start = 1; addr = AW'(b * 4); gw = 1; din = pat(b * 4, 0);
      tick();
      ref_mem[b * 4] = pat(b * 4, 0);
      chk(dout_drv === 1'b0, "R8 write cycle not driven", W'(dout_drv), W'(0));
      cs_start = 0;
      for (int k = 1; k < 4; k++) begin
        adv = 1; gw = 1; din = pat(b * 4 + k, 0);
        tick();
        ref_mem[b * 4 + k] = pat(b * 4 + k, 0);
      end
      idle_ctl(); cs_start = 1; ce = 0;
      tick();
      chk(dout_drv === 1'b0, "R9 deselect", W'(dout_drv), W'(0));
      idle_ctl(); adv = 1;
      tick();
      chk(dout_drv === 1'b0, "R9 stays idle", W'(dout_drv), W'(0));
    end

    // Read sweep: every start, both orders, five beats, then hold
    for (int o = 0; o < 2; o++) begin
      order_ilv = o[0];
      for (int s = 0; s < DEPTH; s++) begin
        ps_read(s);
        chk_read("R1 start read", s);
        for (int k = 1; k <= 4; k++) begin
          adv = 1;
          tick();
          chk_read(o == 0 ? "R3 linear beat" : "R4 interleaved beat", beat_addr(s, k, o[0]));
        end
        adv = 0;
        tick();
        chk_read("R2 hold without advance", beat_addr(s, 4, o[0]));
      end
    end
    order_ilv = 0;

    // R5 byte lane writes at start beats
    idle_ctl(); cs_start = 1; addr = 5; we = 1; bw = 2'b01; din = 18'h2A5A5;
    tick();
    ref_mem[5][8:0] = din[8:0];
    idle_ctl(); cs_start = 1; addr = 6; we = 1; bw = 2'b10; din = 18'h15A3C;
    tick();
    ref_mem[6][17:9] = din[17:9];
    ps_read(5); chk_read("R5 lane0 only", 5);
    ps_read(6); chk_read("R5 lane1 only", 6);

    // R5 byte write on a continuing beat: start 10 (read), advance writes 11 lane1
    idle_ctl(); cs_start = 1; addr = 10;
    tick();
    chk_read("R6 no write controls reads", 10);
    cs_start = 0; adv = 1; we = 1; bw = 2'b10; din = 18'h3FFFF;
    tick();
    ref_mem[11][17:9] = 9'h1FF;
    ps_read(11); chk_read("R5 continuing beat lane write", 11);

    // R6 full writes
    idle_ctl(); cs_start = 1; addr = 7; we = 1; bw = 2'b11; din = 18'h1B2C3;
    tick();
    ref_mem[7] = 18'h1B2C3;
    idle_ctl(); cs_start = 1; addr = 8; gw = 1; din = 18'h0D00D;
    tick();
    ref_mem[8] = 18'h0D00D;
    ps_read(7); chk_read("R6 we with all selects", 7);
    ps_read(8); chk_read("R6 global write", 8);
    idle_ctl(); cs_start = 1; addr = 9; bw = 2'b11; din = 18'h00FFF;
    tick();
    chk_read("R6 selects without we ignored", 9);

    // R7 processor start ignores write controls; priority over controller
    idle_ctl(); ps_start = 1; addr = 3; gw = 1; we = 1; bw = 2'b11; din = 18'h3C3C3;
    tick();
    chk_read("R7 ps start is read", 3);
    idle_ctl(); ps_start = 1; cs_start = 1; addr = 4; gw = 1; din = 18'h3C3C3;
    tick();
    chk_read("R7 ps wins over cs", 4);
    ps_read(3); chk_read("R7 ps start left memory", 3);

    // R8 asynchronous output enable
    ps_read(2);
    oe = 0; #1;
    chk(dout_drv === 1'b0, "R8 oe low", W'(dout_drv), W'(0));
    chk(dout === '0, "R8 undriven output zero", dout, '0);
    oe = 1; #1;
    chk_read("R8 oe high again", 2);

    // R10 sleep blocks write and advance
    ps_read(12);
    adv = 1; gw = 1; din = 18'h12345; sleep = 1; #1;
    chk(dout_drv === 1'b0, "R10 sleep off", W'(dout_drv), W'(0));
    tick(); tick();
    chk(dout_drv === 1'b0, "R10 sleep still off", W'(dout_drv), W'(0));
    sleep = 0; gw = 0; adv = 0; #1;
    chk_read("R10 held address after sleep", 12);
    adv = 1;
    tick();
    chk_read("R10 no write during sleep", 13);

    // R11 reset mid-burst
    idle_ctl(); rst = 1;
    tick();
    rst = 0;
    chk(dout_drv === 1'b0, "R11 reset mid-burst", W'(dout_drv), W'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule